// File: doc/BRIEF.md
# GPIO Input Delay and Interrupt Unit

This block samples a bank of input pins, shifts each one through its own short delay line whose length software picks per channel (zero to three clocks), and presents the delayed levels as a readable input snapshot. Every channel also watches its delayed level for a programmable condition. The condition can be a level, a falling edge, a rising edge or either edge. When the condition is met, the channel latches a sticky pending bit.

Pending bits are qualified by per-channel enables to form a masked status word. Any masked bit that is set drives the single interrupt line. Software clears pending bits by writing ones to a clear location. All configuration and status is reached over a small word-addressed register bus. Writes take effect at the clock edge. Reads return data one cycle after the request, marked by a valid strobe.

Top module: `gpio_dly_irq`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and the delay taps and edge history are 0.
- R2: The delay word at offset 0x14 holds a 2-bit field per channel n at bits [2n+1:2n]. Code k (0..3) makes that channel's delayed level follow its pin after k clock edges, with code 0 passing the pin through combinationally.
- R3: A read at offset 0x18 returns the delayed level of channel n at bit n. Each read request (`bus_en_i`=1, `bus_we_i`=0) yields `bus_rvalid_o`=1 with the data in the next cycle, and `bus_rvalid_o` is 0 in any cycle that does not follow a read request.
- R4: The mode word at offset 0x1C holds a 3-bit field per channel n at bits [3n+2:3n]. Codes 0 and 1 never trigger, code 2 triggers while the delayed level is 0, and code 3 triggers while it is 1.
- R5: Mode code 4 triggers on a falling edge, code 5 on a rising edge, and codes 6 and 7 on either edge. An edge is a difference between the delayed level and its value one clock earlier.
- R6: The pending word at offset 0x20 has bit n set at the clock edge after channel n triggers, and the bit stays set until it is cleared. Writes to 0x20 have no effect.
- R7: Writing a 1 to bit n of offset 0x2C clears pending bit n. If a trigger occurs in the same cycle as the clear, the trigger wins and the bit stays set. Offset 0x2C reads as 0.
- R8: The enable word at offset 0x24 is read/write. The read-only status word at 0x28 returns the pending word ANDed with the enable word.
- R9: `irq_o` is 1 exactly when any bit of the status word is 1.
- R10: Writes to read-only or unmapped offsets (0x18, 0x28, any other address) change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | N_CH | Input pin levels, already synchronous to clk_i |
| bus_en_i | input | 1 | Bus access request this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid when bus_rvalid_o is 1 |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | OR of all masked status bits |

## Verification
The assertions assume that `pins_i` is already synchronous to the clock, that bus control is driven cleanly between edges, and that a clear is only meaningful for the bits that software writes. The bench changes pins and bus signals only on falling edges and never issues a read and a write in the same cycle. Before it arms any edge mode, it holds the pins steady for several cycles so that the taps and edge history have settled, and no reset-time history can be mistaken for an edge.

// File: rtl/gdi_pkg.sv
package gdi_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DLY_W  = 2;
  localparam int unsigned MODE_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DLY  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IN   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h2C;

  typedef enum logic [MODE_W-1:0] {
    TM_OFF_A  = 3'd0,
    TM_OFF_B  = 3'd1,
    TM_LOW    = 3'd2,
    TM_HIGH   = 3'd3,
    TM_FALL   = 3'd4,
    TM_RISE   = 3'd5,
    TM_BOTH_A = 3'd6,
    TM_BOTH_B = 3'd7
  } trig_mode_e;
endpackage

// File: rtl/gdi_delay_line.sv
module gdi_delay_line #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             dout_o
);
  localparam int unsigned MAX_DLY = (1 << SEL_W) - 1;

  logic [MAX_DLY:0] tap;

  assign tap[0] = din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap[MAX_DLY:1] <= '0;
    else         tap[MAX_DLY:1] <= tap[MAX_DLY-1:0];
  end

  assign dout_o = tap[sel_i];
endmodule

// File: rtl/gdi_trig_detect.sv
module gdi_trig_detect
  import gdi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              trig_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (trig_mode_e'(mode_i))
      TM_LOW:              trig_o = ~lvl_i;
      TM_HIGH:             trig_o = lvl_i;
      TM_FALL:             trig_o = fall;
      TM_RISE:             trig_o = rise;
      TM_BOTH_A, TM_BOTH_B: trig_o = rise | fall;
      default:             trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gdi_csr.sv
module gdi_csr
  import gdi_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned DW   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_en_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DW-1:0]            bus_wdata_i,
  output logic [DW-1:0]            bus_rdata_o,
  output logic                     bus_rvalid_o,
  input  logic [N_CH-1:0]          in_lvl_i,
  input  logic [N_CH-1:0]          trig_i,
  output logic [DLY_W*N_CH-1:0]    dly_o,
  output logic [MODE_W*N_CH-1:0]   mode_o,
  output logic [N_CH-1:0]          raw_o,
  output logic [N_CH-1:0]          ena_o,
  output logic [N_CH-1:0]          stat_o
);
  localparam int unsigned DLY_BITS  = DLY_W * N_CH;
  localparam int unsigned MODE_BITS = MODE_W * N_CH;

  logic [DLY_BITS-1:0]  dly_q;
  logic [MODE_BITS-1:0] mode_q;
  logic [N_CH-1:0]      raw_q, ena_q, clr_mask, stat;
  logic [DW-1:0]        rd_mux, rdata_q;
  logic                 rvalid_q, wr_hit, rd_hit;
  logic                 unused_wdata;

  assign wr_hit   = bus_en_i & bus_we_i;
  assign rd_hit   = bus_en_i & ~bus_we_i;
  assign clr_mask = (wr_hit && bus_addr_i == OFS_CLR) ? bus_wdata_i[N_CH-1:0] : '0;
  assign stat     = raw_q & ena_q;
  assign unused_wdata = ^bus_wdata_i[DW-1:MODE_BITS];

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr_i)
      OFS_DLY:  rd_mux[DLY_BITS-1:0]  = dly_q;
      OFS_IN:   rd_mux[N_CH-1:0]      = in_lvl_i;
      OFS_MODE: rd_mux[MODE_BITS-1:0] = mode_q;
      OFS_RAW:  rd_mux[N_CH-1:0]      = raw_q;
      OFS_ENA:  rd_mux[N_CH-1:0]      = ena_q;
      OFS_STAT: rd_mux[N_CH-1:0]      = stat;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= '0;
      mode_q   <= '0;
      ena_q    <= '0;
      raw_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      // trigger has priority over a same-cycle clear
      raw_q    <= (raw_q & ~clr_mask) | trig_i;
      rvalid_q <= rd_hit;
      if (rd_hit) rdata_q <= rd_mux;
      if (wr_hit) begin
        unique case (bus_addr_i)
          OFS_DLY:  dly_q  <= bus_wdata_i[DLY_BITS-1:0];
          OFS_MODE: mode_q <= bus_wdata_i[MODE_BITS-1:0];
          OFS_ENA:  ena_q  <= bus_wdata_i[N_CH-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign dly_o        = dly_q;
  assign mode_o       = mode_q;
  assign raw_o        = raw_q;
  assign ena_o        = ena_q;
  assign stat_o       = stat;
endmodule

// File: rtl/gpio_dly_irq.sv
module gpio_dly_irq
  import gdi_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned DW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   pins_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  logic [DLY_W*N_CH-1:0]  dly_w;
  logic [MODE_W*N_CH-1:0] mode_w;
  logic [N_CH-1:0]        lvl_w, trig_w, raw_w, ena_w, stat_w;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    gdi_delay_line #(.SEL_W(DLY_W)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (pins_i[g]),
      .sel_i  (dly_w[DLY_W*g +: DLY_W]),
      .dout_o (lvl_w[g])
    );

    gdi_trig_detect u_trig (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl_w[g]),
      .mode_i (mode_w[MODE_W*g +: MODE_W]),
      .trig_o (trig_w[g])
    );
  end

  gdi_csr #(.N_CH(N_CH), .DW(DW)) u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_en_i     (bus_en_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .in_lvl_i     (lvl_w),
    .trig_i       (trig_w),
    .dly_o        (dly_w),
    .mode_o       (mode_w),
    .raw_o        (raw_w),
    .ena_o        (ena_w),
    .stat_o       (stat_w)
  );

  assign irq_o = |stat_w;
endmodule

// File: rtl/gpio_dly_irq_chk.sv
module gpio_dly_irq_chk
  import gdi_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N_CH-1:0]   clr_bits_i,
  input logic              bus_rvalid_o,
  input logic              irq_o,
  input logic [N_CH-1:0]   raw_i,
  input logic [N_CH-1:0]   ena_i,
  input logic [N_CH-1:0]   trig_i
);
  logic clr_wr;
  assign clr_wr = bus_en_i && bus_we_i && (bus_addr_i == OFS_CLR);

  // R6: pending bits only fall through a clear write
  a_r6_raw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> (($past(raw_i) & ~raw_i) == '0));

  // R6: a trigger always lands in the pending word
  a_r6_trig_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i != '0) |=> ((raw_i & $past(trig_i)) == $past(trig_i)));

  // R7: cleared bits drop unless re-triggered
  a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((raw_i & $past(clr_bits_i) & ~$past(trig_i)) == '0));

  // R9: no enables, no interrupt
  a_r9_no_ena_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i == '0) |-> !irq_o);

  // R3: valid strobe follows a read request
  a_r3_rvalid_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_we_i) |=> bus_rvalid_o);

  a_r3_rvalid_only_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_en_i && !bus_we_i) |=> !bus_rvalid_o);
endmodule

bind gpio_dly_irq gpio_dly_irq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_en_i     (bus_en_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .clr_bits_i   (bus_wdata_i[N_CH-1:0]),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .raw_i        (raw_w),
  .ena_i        (ena_w),
  .trig_i       (trig_w)
);

// File: tb/sim_gpio_dly_irq.sv
module sim_gpio_dly_irq;
  localparam int N = 8;
  localparam int W = 32;
  localparam logic [5:0] A_DLY = 6'h14, A_IN = 6'h18, A_MODE = 6'h1C, A_RAW = 6'h20,
                         A_ENA = 6'h24, A_STAT = 6'h28, A_CLR = 6'h2C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         en = 1'b0, we = 1'b0;
  logic [5:0]   addr = '0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] rdata;
  logic         rvalid, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  gpio_dly_irq #(.N_CH(N), .DW(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .irq_o(irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected read data: got %h expected none", rdata);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s read: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
    en = 1'b1; we = 1'b1; addr = a; wd = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [W-1:0] e, input string t);
    en = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string t, input logic got, input logic e);
    n_run++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s irq: got %0b expected %0b", t, got, e);
    end
  endtask

  function automatic logic [W-1:0] mode_word();
    logic [W-1:0] v = '0;
    for (int c = 0; c < N; c++) v |= W'(c) << (3 * c);
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", irq, 1'b0);
    rd(A_DLY, '0, "R1 dly");
    rd(A_IN, '0, "R1 in");
    rd(A_MODE, '0, "R1 mode");
    rd(A_RAW, '0, "R1 raw");
    rd(A_ENA, '0, "R1 ena");
    rd(A_STAT, '0, "R1 stat");

    // R2 R3: delays 0,1,2,3 on channels 0..3
    wr(A_DLY, 32'hE4);
    idle(4);
    rd(A_DLY, 32'hE4, "R2 dly readback");
    pins = 8'h0F;
    rd(A_IN, 32'h01, "R2 tap0");
    rd(A_IN, 32'h03, "R2 tap1");
    rd(A_IN, 32'h07, "R2 tap2");
    rd(A_IN, 32'h0F, "R3 tap3");

    // R4 R5: channel c uses mode code c
    wr(A_DLY, '0);
    pins = 8'h00;
    idle(4);
    wr(A_MODE, mode_word());
    wr(A_CLR, 32'hFF);
    idle(2);
    rd(A_MODE, mode_word(), "R4 mode readback");
    rd(A_RAW, 32'h04, "R4 low level");
    pins = 8'hFF;
    idle(1);
    rd(A_RAW, 32'hEC, "R5 rise and high");
    wr(A_CLR, 32'hFF);
    rd(A_RAW, 32'h08, "R7 clear, high level re-sets");
    pins = 8'h00;
    idle(1);
    rd(A_RAW, 32'hDC, "R5 fall and low");

    // R8 R9 masking
    wr(A_ENA, 32'h30);
    chk("R9 enabled pending", irq, 1'b1);
    rd(A_STAT, 32'h10, "R8 masked status");
    rd(A_ENA, 32'h30, "R8 ena readback");
    wr(A_ENA, 32'h01);
    chk("R9 masked off", irq, 1'b0);
    rd(A_STAT, 32'h00, "R8 masked status zero");

    // R7 clear collides with active low level
    wr(A_CLR, 32'h04);
    rd(A_RAW, 32'hDC, "R7 trigger wins");
    wr(A_CLR, 32'hFF);
    rd(A_RAW, 32'h04, "R7 clear all");
    rd(A_CLR, 32'h00, "R7 clear reads zero");

    // R6 R10 ignored writes
    wr(A_RAW, 32'hFF);
    wr(A_STAT, 32'hFF);
    wr(A_IN, 32'hFF);
    wr(6'h00, 32'hFF);
    rd(A_RAW, 32'h04, "R6 raw write ignored");
    rd(A_IN, 32'h00, "R10 in write ignored");
    rd(A_STAT, 32'h00, "R10 stat write ignored");
    rd(A_ENA, 32'h01, "R10 ena untouched");
    rd(6'h00, 32'h00, "R10 unmapped reads zero");

    // R2 R5 R9 rising edge through a 3-cycle delay on channel 5
    wr(A_MODE, 32'h5 << 15);
    wr(A_CLR, 32'hFF);
    wr(A_ENA, 32'h20);
    wr(A_DLY, 32'h3 << 10);
    idle(4);
    chk("R9 idle before edge", irq, 1'b0);
    pins = 8'h20;
    idle(1); chk("R2 edge after 1", irq, 1'b0);
    idle(1); chk("R2 edge after 2", irq, 1'b0);
    idle(1); chk("R2 edge after 3", irq, 1'b0);
    idle(1); chk("R5 delayed rise", irq, 1'b1);
    rd(A_RAW, 32'h20, "R5 delayed rise raw");

    idle(3);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3 reads outstanding: got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule